// File: doc/BRIEF.md
# Dual-Bandwidth Carrier Phase Tracking Loop

This block tracks a carrier from a stream of sampled phase words and recovers the phase message riding on it. Each accepted sample carries a phase expressed as an unsigned 16-bit fraction of a cycle. The loop subtracts the phase of its own numerically controlled oscillator (NCO) from that sample. The wrapped signed difference is the phase error. It is brought out directly as the demodulated signal, and it also drives a proportional-integral filter whose output trims the NCO frequency.

After reset the loop runs in an acquisition mode. This mode uses a wide-bandwidth pair of shift-coded gains so that the loop can pull in a frequency offset. A lock detector smooths the error magnitude. Once the smoothed value stays under a lock threshold for a set run of samples, the loop moves to a narrow-bandwidth tracking pair. If the smoothed value later climbs above a higher release threshold, the loop returns to acquisition.

On every mode change the integrator is reloaded with a compensation value. Because of this reload, the control output computed with the new gains on the same error equals the one computed with the old gains, so the NCO frequency has no step at the change.

Top module: `carrier_gear_pll`

## Requirements
- R1: One cycle after a sample with `smp_valid` high, `demod` holds `smp_phase` minus the previous `nco_phase`, taken modulo 2^16 as a signed two's-complement value (0x8000 reads as -32768).
- R2: During and after reset, `nco_phase`, `ctrl_word`, `demod`, `lock_metric` and `hold_lock` are zero and `track_mode` is 0 (acquisition).
- R3: On each valid sample the NCO phase advances modulo 2^16 by `base_freq` plus the `ctrl_word` value that is produced on that same sample.
- R4: With e the error scaled by 2^16, the proportional term is e arithmetically shifted right by the mode's proportional shift. The integrator adds e shifted right by the mode's integral shift. `ctrl_word` is bits 31:16 of the sum of the proportional term and the updated integrator. Acquisition uses the `acq_*` shifts and tracking uses the `trk_*` shifts.
- R5: On each valid sample `lock_metric` becomes m + ((a - m) >>> 4), with a = min(|error|, 32767). `hold_lock` is 1 when the new metric is strictly below `lock_thr`.
- R6: In acquisition the loop enters tracking on the valid sample that completes `lock_len` consecutive samples whose metric is below `lock_thr` (a `lock_len` of 0 acts as 1). A sample at or above the threshold restarts the run.
- R7: In tracking, a valid sample whose new metric is strictly above `release_thr` returns the loop to acquisition.
- R8: On the sample that changes the mode, `ctrl_word` is computed with the old gains. The integrator is then loaded with that control value minus the new mode's proportional term on the same error.
- R9: Cycles with `smp_valid` low change no output.
- R10: The integrator and the control sum saturate at the signed 32-bit limits instead of wrapping, so a large positive error holds `ctrl_word` at 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_phase | input | 16 | Input phase, fraction of a cycle |
| base_freq | input | 16 | Nominal NCO step per sample |
| acq_kp_sh | input | 4 | Acquisition proportional shift |
| acq_ki_sh | input | 4 | Acquisition integral shift |
| trk_kp_sh | input | 4 | Tracking proportional shift |
| trk_ki_sh | input | 4 | Tracking integral shift |
| lock_thr | input | 16 | Metric level for lock |
| release_thr | input | 16 | Metric level for lock loss |
| lock_len | input | 16 | Consecutive samples needed for lock |
| demod | output | 16 | Signed phase error, demodulated message |
| nco_phase | output | 16 | NCO phase |
| ctrl_word | output | 16 | Frequency trim from the loop filter |
| lock_metric | output | 16 | Smoothed error magnitude |
| hold_lock | output | 1 | Metric below lock threshold |
| track_mode | output | 1 | 1 in tracking, 0 in acquisition |

## Verification
A corrupted integrator shows at the ports on the very next valid sample, as a wrong `ctrl_word`. From then on `nco_phase` and `demod` drift away from the expected values sample after sample. A missing compensation at a mode change therefore appears within one sample of `track_mode` toggling. A bad metric or run counter moves the edge of `track_mode` by at least one sample. The bench checks every output after every sample against a model built from the requirements, so any of these faults is reported at the first sample where it takes effect.

// File: rtl/carrier_gear_pll.sv
module carrier_gear_pll #(
  parameter int PW = 16,
  parameter int IW = 32,
  parameter int SW = 4,
  parameter int CW = 16,
  parameter int MS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [PW-1:0] smp_phase,
  input  logic [PW-1:0] base_freq,
  input  logic [SW-1:0] acq_kp_sh,
  input  logic [SW-1:0] acq_ki_sh,
  input  logic [SW-1:0] trk_kp_sh,
  input  logic [SW-1:0] trk_ki_sh,
  input  logic [PW-1:0] lock_thr,
  input  logic [PW-1:0] release_thr,
  input  logic [CW-1:0] lock_len,
  output logic [PW-1:0] demod,
  output logic [PW-1:0] nco_phase,
  output logic [PW-1:0] ctrl_word,
  output logic [PW-1:0] lock_metric,
  output logic          hold_lock,
  output logic          track_mode
);
  localparam logic signed [IW-1:0] SMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] SMIN = {1'b1, {(IW-1){1'b0}}};
  localparam logic [PW:0] AMAX = {2'b00, {(PW-1){1'b1}}};

  function automatic logic signed [IW-1:0] sat(input logic signed [IW:0] x);
    if (x[IW] != x[IW-1]) return x[IW] ? SMIN : SMAX;
    return x[IW-1:0];
  endfunction

  logic signed [IW-1:0] integ;
  logic [CW-1:0] run_cnt;

  logic signed [PW-1:0] err;
  logic signed [IW-1:0] err_s, prop, iinc, inext, cnext, prop_alt, icomp;
  logic [SW-1:0] kp, ki, kp_alt;
  logic [PW:0] aerr;
  logic [PW-1:0] aclamp, mnext;
  logic signed [PW+1:0] mdiff, mstep;
  logic [CW:0] run_inc;
  logic below, above, to_trk, to_acq;

  assign err    = $signed(smp_phase - nco_phase);
  assign err_s  = {err, {(IW-PW){1'b0}}};
  assign kp     = track_mode ? trk_kp_sh : acq_kp_sh;
  assign ki     = track_mode ? trk_ki_sh : acq_ki_sh;
  assign kp_alt = track_mode ? acq_kp_sh : trk_kp_sh;
  assign prop   = err_s >>> kp;
  assign iinc   = err_s >>> ki;
  assign prop_alt = err_s >>> kp_alt;
  assign inext  = sat({integ[IW-1], integ} + {iinc[IW-1], iinc});
  assign cnext  = sat({prop[IW-1], prop} + {inext[IW-1], inext});
  assign icomp  = sat({cnext[IW-1], cnext} - {prop_alt[IW-1], prop_alt});

  assign aerr   = err[PW-1] ? -{err[PW-1], err} : {1'b0, err};
  assign aclamp = (aerr > AMAX) ? AMAX[PW-1:0] : aerr[PW-1:0];
  assign mdiff  = $signed({2'b00, aclamp}) - $signed({2'b00, lock_metric});
  assign mstep  = mdiff >>> MS;
  assign mnext  = lock_metric + mstep[PW-1:0];
  assign below  = mnext < lock_thr;
  assign above  = mnext > release_thr;
  assign run_inc = {1'b0, run_cnt} + 1'b1;
  assign to_trk = !track_mode && below && (run_inc >= {1'b0, lock_len});
  assign to_acq = track_mode && above;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ       <= '0;
      run_cnt     <= '0;
      demod       <= '0;
      nco_phase   <= '0;
      ctrl_word   <= '0;
      lock_metric <= '0;
      hold_lock   <= 1'b0;
      track_mode  <= 1'b0;
    end else if (smp_valid) begin
      demod       <= err;
      ctrl_word   <= cnext[IW-1 -: PW];
      nco_phase   <= nco_phase + base_freq + cnext[IW-1 -: PW];
      lock_metric <= mnext;
      hold_lock   <= below;
      if (to_trk || to_acq) begin
        integ      <= icomp;
        track_mode <= ~track_mode;
        run_cnt    <= '0;
      end else begin
        integ   <= inext;
        run_cnt <= (!track_mode && below) ? run_inc[CW-1:0] : '0;
      end
    end
  end

  a_r1_error_out: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> demod == $past(smp_phase) - $past(nco_phase));
  a_r3_nco_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> nco_phase == $past(nco_phase) + $past(base_freq) + ctrl_word);
  a_r6_lock_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_mode) |-> hold_lock && lock_metric < $past(lock_thr));
  a_r7_release_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track_mode) |-> lock_metric > $past(release_thr));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(nco_phase) && $stable(ctrl_word) && $stable(track_mode)
                   && $stable(lock_metric) && $stable(demod));
endmodule

// File: tb/carrier_gear_pll_test.sv
`timescale 1ns/1ps
module carrier_gear_pll_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_phase = '0, base_freq = '0;
  logic [3:0] acq_kp_sh = 4'd2, acq_ki_sh = 4'd6, trk_kp_sh = 4'd5, trk_ki_sh = 4'd10;
  logic [15:0] lock_thr = 16'd300, release_thr = 16'd2000, lock_len = 16'd8;
  logic [15:0] demod, nco_phase, ctrl_word, lock_metric;
  logic hold_lock, track_mode;

  int checks = 0, failures = 0;
  longint m_nco, m_int, m_met, m_cnt, m_ctrl, m_dem;
  int m_trk, m_hold;

  carrier_gear_pll uut (.*);

  always #2.5 clk = ~clk;

  function automatic longint sat32(input longint x);
    if (x > 64'sd2147483647) return 64'sd2147483647;
    if (x < -64'sd2147483648) return -64'sd2147483648;
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model_reset();
    m_nco = 0; m_int = 0; m_met = 0; m_cnt = 0; m_ctrl = 0; m_dem = 0; m_trk = 0; m_hold = 0;
  endtask

  task automatic model_step(input logic [15:0] ph);
    longint e, es, kp, ki, kpa, p, pa, inx, c, a, cw;
    bit below, above;
    e = longint'($signed(16'(ph - 16'(m_nco))));
    es = e * 65536;
    kp  = m_trk ? trk_kp_sh : acq_kp_sh;
    ki  = m_trk ? trk_ki_sh : acq_ki_sh;
    kpa = m_trk ? acq_kp_sh : trk_kp_sh;
    p = es >>> kp; pa = es >>> kpa;
    inx = sat32(m_int + (es >>> ki));
    c = sat32(p + inx);
    cw = c >>> 16;
    a = (e < 0) ? -e : e;
    if (a > 32767) a = 32767;
    m_met = m_met + ((a - m_met) >>> 4);
    below = m_met < lock_thr;
    above = m_met > release_thr;
    m_dem = e & 16'hFFFF;
    m_ctrl = cw & 16'hFFFF;
    m_nco = (m_nco + base_freq + cw) & 16'hFFFF;
    m_hold = below;
    if ((!m_trk && below && (m_cnt + 1 >= lock_len)) || (m_trk && above)) begin
      m_int = sat32(c - pa); m_trk = !m_trk; m_cnt = 0;
    end else begin
      m_int = inx;
      m_cnt = (!m_trk && below) ? m_cnt + 1 : 0;
    end
  endtask

  task automatic compare(input string req);
    check({req, " demod"}, demod, m_dem);
    check({req, " nco_phase"}, nco_phase, m_nco);
    check({req, " ctrl_word"}, ctrl_word, m_ctrl);
    check({req, " lock_metric"}, lock_metric, m_met);
    check({req, " hold_lock"}, hold_lock, m_hold);
    check({req, " track_mode"}, track_mode, m_trk);
  endtask

  task automatic apply(input logic [15:0] ph, input string req);
    @(negedge clk);
    smp_valid = 1'b1; smp_phase = ph;
    @(negedge clk);
    smp_valid = 1'b0;
    model_step(ph);
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; smp_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 nco_phase", nco_phase, 0); check("R2 ctrl_word", ctrl_word, 0);
    check("R2 demod", demod, 0); check("R2 lock_metric", lock_metric, 0);
    check("R2 hold_lock", hold_lock, 0); check("R2 track_mode", track_mode, 0);
    do_reset();
    check("R2 after release", track_mode, 0);
  endtask

  task automatic t_wrap();
    do_reset(); base_freq = 0; acq_kp_sh = 4'd15; acq_ki_sh = 4'd15;
    apply(16'h8000, "R1 half cycle");
    check("R1 half cycle value", demod, 16'h8000);
    do_reset();
    apply(16'h7FFF, "R1 max positive");
    check("R1 +32767", demod, 16'h7FFF);
    do_reset();
    apply(16'h8001, "R1 near negative");
    check("R1 -32767", demod, 16'h8001);
    check("R5 clamp metric", lock_metric, 2047);
  endtask

  task automatic t_sat();
    do_reset(); base_freq = 0; acq_kp_sh = 4'd15; acq_ki_sh = 4'd0;
    apply(16'h7FFF, "R10 first");
    apply(16'(m_nco + 16'h7FFF), "R10 second");
    check("R10 ctrl saturated", ctrl_word, 16'h7FFF);
    apply(16'(m_nco + 16'h7FFF), "R10 third");
    check("R10 ctrl held", ctrl_word, 16'h7FFF);
  endtask

  task automatic t_lock_run();
    logic [15:0] ph;
    do_reset(); base_freq = 16'h1000; lock_thr = 16'd100; lock_len = 16'd5;
    acq_kp_sh = 4'd2; acq_ki_sh = 4'd6;
    ph = 0;
    for (int i = 1; i <= 5; i++) begin
      apply(ph, "R6 run");
      if (i == 4) check("R6 not yet tracking", track_mode, 0);
      ph += 16'h1000;
    end
    check("R6 tracking after run", track_mode, 1);
    check("R5 hold_lock", hold_lock, 1);
    do_reset(); lock_len = 16'd0;
    apply(16'h0000, "R6 zero length");
    check("R6 zero length acts as one", track_mode, 1);
  endtask

  task automatic t_offset();
    logic [15:0] ph;
    int seen;
    do_reset(); base_freq = 16'h1000; lock_thr = 16'd300; release_thr = 16'd2000;
    lock_len = 16'd8; acq_kp_sh = 4'd2; acq_ki_sh = 4'd6; trk_kp_sh = 4'd5; trk_ki_sh = 4'd10;
    ph = 16'h2000; seen = 0;
    for (int i = 0; i < 300; i++) begin
      apply(ph, m_trk ? "R8 R4 tracking" : "R3 R4 acquiring");
      if (m_trk) seen = 1;
      ph += 16'h1180 + ((i % 16 < 8) ? 16'h0040 : 16'h0000);
    end
    check("R6 R8 lock reached during offset", seen, 1);
  endtask

  task automatic t_release();
    for (int i = 0; i < 12; i++) apply(16'(m_nco + 16'h4000), "R7 step");
    check("R7 back to acquisition", track_mode, 0);
  endtask

  task automatic t_idle();
    logic [15:0] n, c, m, d;
    logic t;
    n = nco_phase; c = ctrl_word; m = lock_metric; d = demod; t = track_mode;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); smp_phase = 16'(i * 16'h1357);
    end
    @(negedge clk);
    check("R9 nco idle", nco_phase, n); check("R9 ctrl idle", ctrl_word, c);
    check("R9 metric idle", lock_metric, m); check("R9 demod idle", demod, d);
    check("R9 mode idle", track_mode, t);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    t_reset();
    t_wrap();
    t_sat();
    t_lock_run();
    t_offset();
    t_idle();
    t_release();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule